// File: doc/BRIEF.md
# SPI Configuration Bank with Serial Forwarder

This block is a bank of 36 sixteen-bit configuration registers that a host loads over an SPI slave port. Every register drives the block's outputs, so the register image is always visible to the rest of the chip. Named views pick out the 24 filter coefficients, the rough audio attenuation word and the enable for the 8 kHz audio interrupt.

The four lowest registers belong to a downstream receiver device. A successful write to any of them also queues a serial frame on a one-wire programming line. The frame is sent one bit per rising edge of a reference clock that the downstream device supplies. One such use is the initial write that moves that device's reference clock from 4.8 MHz to 2.4 MHz.

The block does nothing while that reference clock is absent. A presence detector watches the clock. While the detector reports the clock missing, SPI writes are dropped and no frame is shifted out.

Top module: `cfg_bank_fwd`

## Requirements
- R1: After reset every register reads zero, `prog_line` is 1, and `fwd_busy`, `fwd_ovf` and `ref_ok` are 0.
- R2: An SPI frame is 24 bits in mode 0, MSB first. Bit 23 is the write flag (1 = write), bits 22:16 are the register index and bits 15:0 are the data. A write to an index below 36 stores the data in `cfg_flat[16*index +: 16]`.
- R3: None of the following changes any register: a frame with bit 23 equal to 0, a write with an index of 36 or more, or a frame cut short when `spi_cs_n` rises before its 24th bit.
- R4: A stored write to index 0 to 3 produces one 18-bit frame on `prog_line`, MSB first. The frame is the 2-bit index followed by the 16 data bits. `prog_line` moves only just after a rising edge of `ref_clk`, one bit per rising edge. `fwd_busy` is 1 while the frame is on the line, and `prog_line` is 1 whenever no frame is being sent.
- R5: Writes to indices 4 to 35 produce no frame.
- R6: One forward write that arrives during a frame is held and sent after that frame. A forward write that arrives while one is already held sets `fwd_ovf`, which stays 1 until reset. That write's register is still stored, but no frame is sent for it.
- R7: `ref_ok` goes to 1 after a rising edge of `ref_clk`. It goes to 0 once 64 system clocks pass with no rising edge.
- R8: While `ref_ok` is 0, write frames are ignored: no register changes and no frame is sent.
- R9: `tap_flat[16*i +: 16]` is register 4+i for i from 0 to 23. `atten` is register 28. `irq8k_en` is bit 0 of register 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI serial data in |
| ref_clk | input | 1 | Reference clock from the downstream device |
| prog_line | output | 1 | One-wire programming line, idles high |
| fwd_busy | output | 1 | A forward frame is on the line |
| fwd_ovf | output | 1 | Sticky forward overflow flag |
| ref_ok | output | 1 | Reference clock present |
| cfg_flat | output | 576 | All 36 registers, register n at bits 16n+15:16n |
| tap_flat | output | 384 | Filter coefficients 0 to 23 |
| atten | output | 16 | Audio attenuation register |
| irq8k_en | output | 1 | 8 kHz audio interrupt enable |

## Verification
The assertions assume three things about the inputs. `ref_clk`, `spi_sclk` and `spi_mosi` change slowly enough that each level lasts several system clocks through the two-stage synchronizers. `spi_mosi` is stable around each rising edge of `spi_sclk`. A running `ref_clk` has rising edges fewer than 64 system clocks apart. The bench keeps within these limits: its SPI clock has a half period of three system clocks, data changes only while `spi_sclk` is low, and `ref_clk` has a period of 40 system clocks. The clock only stops when the bench deliberately switches it off.

// File: rtl/cfg_bank_fwd.sv
module cfg_bank_fwd #(
  parameter int NREG     = 36,
  parameter int DW       = 16,
  parameter int AW       = 7,
  parameter int NFWD     = 4,
  parameter int NTAPS    = 24,
  parameter int TAP_BASE = 4,
  parameter int ATT_IDX  = 28,
  parameter int IRQ_IDX  = 29,
  parameter int MISS_LIM = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sclk,
  input  logic                 spi_cs_n,
  input  logic                 spi_mosi,
  input  logic                 ref_clk,
  output logic                 prog_line,
  output logic                 fwd_busy,
  output logic                 fwd_ovf,
  output logic                 ref_ok,
  output logic [NREG*DW-1:0]   cfg_flat,
  output logic [NTAPS*DW-1:0]  tap_flat,
  output logic [DW-1:0]        atten,
  output logic                 irq8k_en
);
  localparam int FRAME = 1 + AW + DW;
  localparam int FCW   = $clog2(FRAME + 1);
  localparam int IW    = $clog2(NREG);
  localparam int SELW  = $clog2(NFWD);
  localparam int FW    = SELW + DW;
  localparam int BCW   = $clog2(FW + 1);
  localparam int MCW   = $clog2(MISS_LIM + 1);

  logic [2:0] sclk_s, ref_s;
  logic [1:0] cs_s, mosi_s;
  logic       sclk_rise, ref_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= '0;
      ref_s  <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], spi_sclk};
      ref_s  <= {ref_s[1:0], ref_clk};
      cs_s   <= {cs_s[0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
    end

  assign sclk_rise = sclk_s[1] & ~sclk_s[2];
  assign ref_rise  = ref_s[1] & ~ref_s[2];

  logic [MCW-1:0] miss_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      miss_cnt <= '0;
      ref_ok   <= 1'b0;
    end else if (ref_rise) begin
      miss_cnt <= '0;
      ref_ok   <= 1'b1;
    end else if (miss_cnt == MCW'(MISS_LIM - 1)) begin
      ref_ok   <= 1'b0;
    end else begin
      miss_cnt <= miss_cnt + 1'b1;
    end

  logic [FRAME-2:0] spi_sh;
  logic [FCW-1:0]   spi_cnt;
  logic             frame_done;
  logic [FRAME-1:0] frame;
  logic [AW-1:0]    w_idx;
  logic [DW-1:0]    w_data;
  logic             do_store, do_fwd;

  assign frame_done = sclk_rise && !cs_s[1] && (spi_cnt == FCW'(FRAME - 1));
  assign frame      = {spi_sh, mosi_s[1]};
  assign w_idx      = frame[DW +: AW];
  assign w_data     = frame[DW-1:0];
  assign do_store   = frame_done && frame[FRAME-1] && ref_ok && (w_idx < AW'(NREG));
  assign do_fwd     = do_store && (w_idx < AW'(NFWD));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      spi_sh  <= '0;
      spi_cnt <= '0;
    end else if (cs_s[1]) begin
      spi_cnt <= '0;
    end else if (sclk_rise) begin
      spi_sh  <= {spi_sh[FRAME-3:0], mosi_s[1]};
      spi_cnt <= frame_done ? '0 : spi_cnt + 1'b1;
    end

  logic [DW-1:0] regs [NREG];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (do_store) begin
      regs[w_idx[IW-1:0]] <= w_data;
    end

  for (genvar g = 0; g < NREG; g++) begin : g_cfg
    assign cfg_flat[g*DW +: DW] = regs[g];
  end
  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    assign tap_flat[t*DW +: DW] = regs[TAP_BASE + t];
  end
  assign atten    = regs[ATT_IDX];
  assign irq8k_en = regs[IRQ_IDX][0];

  logic [FW-1:0]  fwd_sh, pend_w;
  logic [BCW-1:0] bit_cnt;
  logic           active, pend_v, start;

  assign start = ref_rise && !active && pend_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active  <= 1'b0;
      fwd_sh  <= '0;
      bit_cnt <= '0;
    end else if (ref_rise) begin
      if (active) begin
        if (bit_cnt == BCW'(FW - 1)) active <= 1'b0;
        else begin
          fwd_sh  <= {fwd_sh[FW-2:0], 1'b1};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (pend_v) begin
        active  <= 1'b1;
        fwd_sh  <= pend_w;
        bit_cnt <= '0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_v  <= 1'b0;
      pend_w  <= '0;
      fwd_ovf <= 1'b0;
    end else if (do_fwd) begin
      if (pend_v && !start) fwd_ovf <= 1'b1;
      else begin
        pend_v <= 1'b1;
        pend_w <= {w_idx[SELW-1:0], w_data};
      end
    end else if (start) begin
      pend_v <= 1'b0;
    end

  assign fwd_busy  = active;
  assign prog_line = active ? fwd_sh[FW-1] : 1'b1;
endmodule

// File: rtl/cfg_bank_fwd_chk.sv
module cfg_bank_fwd_chk #(
  parameter int W = 576
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ref_rise,
  input logic         prog_line,
  input logic         fwd_busy,
  input logic         fwd_ovf,
  input logic         ref_ok,
  input logic [W-1:0] cfg_flat
);
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_busy |-> prog_line);

  p_line_moves_on_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_rise |=> $stable(prog_line));

  p_no_overflow_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_ovf |=> fwd_ovf);

  p_busy_needs_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_busy) |-> ref_ok);

  p_frozen_without_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ok |=> $stable(cfg_flat));
endmodule

bind cfg_bank_fwd cfg_bank_fwd_chk #(.W(NREG*DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .prog_line(prog_line),
  .fwd_busy(fwd_busy), .fwd_ovf(fwd_ovf), .ref_ok(ref_ok), .cfg_flat(cfg_flat)
);

// File: tb/test_cfg_bank_fwd.sv
`timescale 1ns/1ps
module test_cfg_bank_fwd;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, cs_n = 1, mosi = 0, ref_clk = 0;
  logic prog_line, fwd_busy, fwd_ovf, ref_ok, irq8k_en;
  logic [575:0] cfg_flat;
  logic [383:0] tap_flat;
  logic [15:0]  atten;
  bit ref_run = 0;
  int n_tests = 0, n_fail = 0, busy_rises = 0;
  bit done = 0;

  cfg_bank_fwd i_cfg_bank_fwd (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .ref_clk(ref_clk), .prog_line(prog_line), .fwd_busy(fwd_busy), .fwd_ovf(fwd_ovf),
    .ref_ok(ref_ok), .cfg_flat(cfg_flat), .tap_flat(tap_flat), .atten(atten),
    .irq8k_en(irq8k_en)
  );

  always #10 clk = ~clk;
  always begin
    if (ref_run) begin #400 ref_clk = ~ref_clk; end
    else #20;
  end
  always @(posedge fwd_busy) busy_rises++;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic spi_send(bit wr, logic [6:0] idx, logic [15:0] d, int nbits);
    logic [23:0] f = {wr, idx, d};
    cs_n = 0; cyc(3);
    for (int i = 23; i > 23 - nbits; i--) begin
      mosi = f[i]; cyc(3);
      sclk = 1;    cyc(3);
      sclk = 0;
    end
    cyc(3); cs_n = 1; cyc(6);
  endtask

  task automatic capture(output logic [17:0] f);
    @(posedge fwd_busy);
    for (int i = 17; i >= 0; i--) begin
      @(negedge ref_clk);
      f[i] = prog_line;
    end
  endtask

  function automatic logic [15:0] reg_of(int n);
    return cfg_flat[n*16 +: 16];
  endfunction

  task automatic t_reset();
    rst_n = 0; cyc(5);
    check("R1 prog_line", {31'd0, prog_line}, 1);
    check("R1 fwd_busy", {31'd0, fwd_busy}, 0);
    check("R1 fwd_ovf", {31'd0, fwd_ovf}, 0);
    check("R1 ref_ok", {31'd0, ref_ok}, 0);
    check("R1 cfg_flat zero", {31'd0, |cfg_flat}, 0);
    rst_n = 1; cyc(100);
    check("R1 ref_ok stays low without clock", {31'd0, ref_ok}, 0);
  endtask

  task automatic t_clock_up();
    ref_run = 1; cyc(150);
    check("R7 ref_ok after edges", {31'd0, ref_ok}, 1);
  endtask

  task automatic t_store();
    int b0 = busy_rises;
    spi_send(1, 7'd4, 16'hA5C3, 24);
    spi_send(1, 7'd27, 16'h0F0F, 24);
    spi_send(1, 7'd28, 16'h0033, 24);
    spi_send(1, 7'd29, 16'h0001, 24);
    spi_send(1, 7'd35, 16'hBEEF, 24);
    cyc(100);
    check("R2 reg4", {16'd0, reg_of(4)}, 32'hA5C3);
    check("R2 reg35", {16'd0, reg_of(35)}, 32'hBEEF);
    check("R9 tap0", {16'd0, tap_flat[15:0]}, 32'hA5C3);
    check("R9 tap23", {16'd0, tap_flat[23*16 +: 16]}, 32'h0F0F);
    check("R9 atten", {16'd0, atten}, 32'h0033);
    check("R9 irq8k_en", {31'd0, irq8k_en}, 1);
    check("R5 no frame for index 4..35", busy_rises - b0, 0);
    check("R5 line idle", {31'd0, prog_line}, 1);
  endtask

  task automatic t_ignored();
    logic [575:0] snap = cfg_flat;
    spi_send(0, 7'd35, 16'h0000, 24);
    spi_send(1, 7'd36, 16'h1111, 24);
    spi_send(1, 7'd127, 16'h2222, 24);
    spi_send(1, 7'd4, 16'h0000, 12);
    cyc(20);
    check("R3 registers unchanged", {31'd0, cfg_flat == snap}, 1);
  endtask

  task automatic t_forward();
    logic [17:0] f;
    fork
      spi_send(1, 7'd2, 16'h9C35, 24);
      capture(f);
    join
    check("R4 frame idx2", {14'd0, f}, {14'd0, 2'b10, 16'h9C35});
    check("R2 reg2 stored", {16'd0, reg_of(2)}, 32'h9C35);
    fork
      spi_send(1, 7'd0, 16'hFFFF, 24);
      capture(f);
    join
    check("R4 frame idx0", {14'd0, f}, {14'd0, 2'b00, 16'hFFFF});
    cyc(100);
    check("R4 idle high after frame", {31'd0, prog_line}, 1);
    check("R4 busy low after frame", {31'd0, fwd_busy}, 0);
  endtask

  task automatic t_overflow();
    logic [17:0] f1, f2;
    int b0 = busy_rises;
    fork
      begin
        spi_send(1, 7'd1, 16'h1234, 24);
        spi_send(1, 7'd3, 16'h5678, 24);
        spi_send(1, 7'd0, 16'h9ABC, 24);
      end
      begin capture(f1); capture(f2); end
    join
    cyc(1000);
    check("R6 first frame", {14'd0, f1}, {14'd0, 2'b01, 16'h1234});
    check("R6 queued frame", {14'd0, f2}, {14'd0, 2'b11, 16'h5678});
    check("R6 overflow set", {31'd0, fwd_ovf}, 1);
    check("R6 dropped frame not sent", busy_rises - b0, 2);
    check("R6 dropped write still stored", {16'd0, reg_of(0)}, 32'h9ABC);
  endtask

  task automatic t_noclk();
    int b0;
    ref_run = 0; cyc(100);
    check("R7 ref_ok falls without clock", {31'd0, ref_ok}, 0);
    b0 = busy_rises;
    spi_send(1, 7'd5, 16'h4321, 24);
    spi_send(1, 7'd1, 16'h7777, 24);
    cyc(10);
    check("R8 reg5 unchanged", {16'd0, reg_of(5)}, 32'h0000);
    check("R8 reg1 unchanged", {16'd0, reg_of(1)}, 32'h1234);
    ref_run = 1; cyc(300);
    check("R7 ref_ok back", {31'd0, ref_ok}, 1);
    check("R8 no frame from ignored write", busy_rises - b0, 0);
  endtask

  initial begin
    t_reset();
    t_clock_up();
    t_store();
    t_ignored();
    t_forward();
    t_overflow();
    t_noclk();
    finish_run();
  end
endmodule